// File: doc/BRIEF.md
# Single-Slope Conversion Timer and Capture Controller

This block is the digital half of a single-slope analog-to-digital converter. Software picks one of sixteen analog inputs and one of sixteen ramp current settings, then releases a ramp-hold bit. From that point an external current source charges a capacitor and an internal timer counts device clocks. The external comparator trips when the ramp voltage passes the input voltage. On the first trip after a ramp release, the timer value is frozen into a capture register and a conversion-done flag is raised. The captured count is the conversion result.

The comparator output arrives asynchronously and passes through a synchroniser. A clock-running input marks cycles in which the device clock is live. While it is low, every state element holds its value. A comparator trip that happens during a clock stop is therefore captured, and flagged, as soon as the clock returns. If the timer wraps past its top value before any trip, a sticky overflow bit is set. Software reads all state through a byte-wide read port and writes control through a byte-wide write port. The reset signal is asynchronous and active low. Its release is synchronised inside the block.

Top module: `slope_adc_ctrl`

## Requirements
- R1: After reset, control register 0 (address 0) reads 0x0F. The bits are ramp hold at bit 3, converter off at bit 2, reference off at bit 1 and oscillator off at bit 0. The status register (address 2) reads 0x00, isrc_en is low, and the three off outputs are high.
- R2: chan_sel equals bits 7:4 of control register 0, and ramp_iset equals bits 7:4 of control register 1 (address 1, which reads back with bits 3:0 at zero). Both take effect in the cycle after the write.
- R3: isrc_en is high only while ramp hold (control 0 bit 3) and converter off (bit 2) are both clear. While ramp hold is set and the clock runs, the timer is cleared to zero.
- R4: While ramp hold and converter off are clear, the 16-bit timer increments by one on every cycle in which clk_run is high. It wraps from 0xFFFF to 0. It reads as a low byte at address 3 and a high byte at address 4.
- R5: A rising edge of cmp_in, after two synchroniser stages, copies the current timer value into the capture register. The capture register reads as a low byte at address 5 and a high byte at address 6. The same edge sets status bit 0 (done), which drives done_irq.
- R6: Only the first comparator rising edge after a ramp hold is captured. Later edges leave the capture register and the status register unchanged.
- R7: A write to status clears each bit whose written value is 0. Writing 1 leaves a bit unchanged. A set event in the same cycle as a clear wins.
- R8: While clk_run is low, the timer, the capture register, the status bits and the synchroniser hold their values. A comparator rise that happens during the stop is captured, and sets done, after clk_run returns.
- R9: If the timer wraps from 0xFFFF while no trip has been captured since the ramp hold, status bit 1 (overflow) is set. It is sticky until it is cleared by a write of 0 to that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_run | input | 1 | High while the device clock is live |
| cmp_in | input | 1 | Asynchronous comparator output, high when the ramp exceeds the input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| chan_sel | output | 4 | Analog input channel select |
| ramp_iset | output | 4 | Ramp current-source setting |
| isrc_en | output | 1 | Ramp current-source enable |
| conv_off | output | 1 | Converter analog power-down |
| ref_off | output | 1 | Reference power-down |
| osc_off | output | 1 | Oscillator power-down |
| done_irq | output | 1 | Conversion-done flag |

## Verification
The assertions assume two things about the inputs. First, cmp_in holds its level for at least three running clock cycles, so that no edge is lost inside the synchroniser. Second, software writes only while clk_run is high. The stimulus changes cmp_in only after long stretches of running cycles or across whole clock stops. It issues every register write with clk_run high. It stops the clock only between writes, so each capture, hold and overflow case stays inside those assumptions.

// File: rtl/slope_adc_pkg.sv
package slope_adc_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  localparam logic [AW-1:0] ADDR_CTL0 = 3'd0;
  localparam logic [AW-1:0] ADDR_CTL1 = 3'd1;
  localparam logic [AW-1:0] ADDR_STAT = 3'd2;
  localparam logic [AW-1:0] ADDR_TLO  = 3'd3;
  localparam logic [AW-1:0] ADDR_THI  = 3'd4;
  localparam logic [AW-1:0] ADDR_CLO  = 3'd5;
  localparam logic [AW-1:0] ADDR_CHI  = 3'd6;

  typedef struct packed {
    logic [3:0] chan;
    logic       ramp_hold;
    logic       conv_off;
    logic       ref_off;
    logic       osc_off;
  } ctl0_t;

  localparam ctl0_t CTL0_RESET = '{chan: 4'h0, ramp_hold: 1'b1, conv_off: 1'b1,
                                   ref_off: 1'b1, osc_off: 1'b1};
endpackage

// File: rtl/slope_adc_sync.sv
module slope_adc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic clk_en,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES-1:0] sr_q, sr_d;
  logic              prev_q, prev_d;

  always_comb begin
    sr_d   = sr_q;
    prev_d = prev_q;
    if (clk_en) begin
      sr_d   = {sr_q[STAGES-2:0], async_in};
      prev_d = sr_q[STAGES-1];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = sr_q[STAGES-1] & ~prev_q;

  // R8: a stopped clock freezes the synchroniser
  assert_sync_hold_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    !clk_en |=> $stable(sr_q) && $stable(prev_q));
endmodule

// File: rtl/slope_adc_timer.sv
module slope_adc_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          clk_en,
  input  logic          ramp_hold,
  input  logic          conv_off,
  input  logic          rise,
  output logic [TW-1:0] tmr_o,
  output logic [TW-1:0] cap_o,
  output logic          trip_o,
  output logic          wrap_o
);
  logic [TW-1:0] tmr_q, tmr_d;
  logic [TW-1:0] cap_q, cap_d;
  logic          armed_q, armed_d;
  logic          run;
  logic          trip;

  assign run  = ~ramp_hold & ~conv_off;
  assign trip = clk_en & rise & armed_q & run;

  always_comb begin
    tmr_d   = tmr_q;
    cap_d   = cap_q;
    armed_d = armed_q;
    if (clk_en) begin
      if (ramp_hold) begin
        tmr_d   = '0;
        armed_d = 1'b1;
      end else begin
        if (!conv_off) tmr_d = tmr_q + 1'b1;
        if (trip) begin
          cap_d   = tmr_q;
          armed_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q   <= '0;
      cap_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      tmr_q   <= tmr_d;
      cap_q   <= cap_d;
      armed_q <= armed_d;
    end
  end

  assign tmr_o  = tmr_q;
  assign cap_o  = cap_q;
  assign trip_o = trip;
  assign wrap_o = clk_en & run & armed_q & ~trip & (&tmr_q);

  // R8: timer and capture hold while the clock is stopped
  assert_timer_hold_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    !clk_en |=> $stable(tmr_q) && $stable(cap_q));
  // R3: ramp hold clears the timer
  assert_hold_clears_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (clk_en && ramp_hold) |=> (tmr_q == '0));
  // R4: counting advances by exactly one
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (clk_en && run) |=> (tmr_q == TW'($past(tmr_q) + 1'b1)));
  // R6: once disarmed, the capture does not move
  assert_single_capture_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    !armed_q |=> $stable(cap_q));
endmodule

// File: rtl/slope_adc_regs.sv
module slope_adc_regs
  import slope_adc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          trip,
  input  logic          wrap,
  output ctl0_t         ctl0_o,
  output logic [3:0]    iset_o,
  output logic          done_o,
  output logic          ovf_o
);
  ctl0_t      ctl0_q, ctl0_d;
  logic [3:0] iset_q, iset_d;
  logic       done_q, done_d;
  logic       ovf_q, ovf_d;

  always_comb begin
    ctl0_d = ctl0_q;
    iset_d = iset_q;
    done_d = done_q;
    ovf_d  = ovf_q;
    if (wr_en) begin
      case (wr_addr)
        ADDR_CTL0: ctl0_d = ctl0_t'(wr_data);
        ADDR_CTL1: iset_d = wr_data[7:4];
        ADDR_STAT: begin
          done_d = done_q & wr_data[0];
          ovf_d  = ovf_q & wr_data[1];
        end
        default: ;
      endcase
    end
    if (trip) done_d = 1'b1;
    if (wrap) ovf_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl0_q <= CTL0_RESET;
      iset_q <= '0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      ctl0_q <= ctl0_d;
      iset_q <= iset_d;
      done_q <= done_d;
      ovf_q  <= ovf_d;
    end
  end

  assign ctl0_o = ctl0_q;
  assign iset_o = iset_q;
  assign done_o = done_q;
  assign ovf_o  = ovf_q;

  // R5: a trip always leaves the done flag set
  assert_done_on_trip_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    trip |=> done_q);
  // R9: a wrap always leaves the overflow bit set
  assert_ovf_on_wrap_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    wrap |=> ovf_q);
endmodule

// File: rtl/slope_adc_ctrl.sv
module slope_adc_ctrl
  import slope_adc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_run,
  input  logic          cmp_in,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [3:0]    chan_sel,
  output logic [3:0]    ramp_iset,
  output logic          isrc_en,
  output logic          conv_off,
  output logic          ref_off,
  output logic          osc_off,
  output logic          done_irq
);
  localparam int TW = 2 * DW;

  logic          rst_meta_q, rst_sync_q;
  logic          rise;
  logic          trip, wrap;
  logic [TW-1:0] tmr, cap;
  ctl0_t         ctl0;
  logic [3:0]    iset;
  logic          done, ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  slope_adc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_ni   (rst_sync_q),
    .clk_en   (clk_run),
    .async_in (cmp_in),
    .rise_o   (rise)
  );

  slope_adc_timer #(.TW(TW)) u_timer (
    .clk       (clk),
    .rst_ni    (rst_sync_q),
    .clk_en    (clk_run),
    .ramp_hold (ctl0.ramp_hold),
    .conv_off  (ctl0.conv_off),
    .rise      (rise),
    .tmr_o     (tmr),
    .cap_o     (cap),
    .trip_o    (trip),
    .wrap_o    (wrap)
  );

  slope_adc_regs u_regs (
    .clk     (clk),
    .rst_ni  (rst_sync_q),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .trip    (trip),
    .wrap    (wrap),
    .ctl0_o  (ctl0),
    .iset_o  (iset),
    .done_o  (done),
    .ovf_o   (ovf)
  );

  always_comb begin
    case (rd_addr)
      ADDR_CTL0: rd_data = ctl0;
      ADDR_CTL1: rd_data = {iset, 4'h0};
      ADDR_STAT: rd_data = {6'h00, ovf, done};
      ADDR_TLO:  rd_data = tmr[DW-1:0];
      ADDR_THI:  rd_data = tmr[TW-1:DW];
      ADDR_CLO:  rd_data = cap[DW-1:0];
      ADDR_CHI:  rd_data = cap[TW-1:DW];
      default:   rd_data = '0;
    endcase
  end

  assign chan_sel  = ctl0.chan;
  assign ramp_iset = iset;
  assign isrc_en   = ~ctl0.ramp_hold & ~ctl0.conv_off;
  assign conv_off  = ctl0.conv_off;
  assign ref_off   = ctl0.ref_off;
  assign osc_off   = ctl0.osc_off;
  assign done_irq  = done;
endmodule

// File: tb/slope_adc_ctrl_bench.sv
module slope_adc_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_run = 1'b1;
  logic       cmp_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;
  logic [3:0] chan_sel, ramp_iset;
  logic       isrc_en, conv_off, ref_off, osc_off, done_irq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  slope_adc_ctrl u_slope_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .clk_run(clk_run), .cmp_in(cmp_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .chan_sel(chan_sel), .ramp_iset(ramp_iset), .isrc_en(isrc_en),
    .conv_off(conv_off), .ref_off(ref_off), .osc_off(osc_off),
    .done_irq(done_irq)
  );

  // behavioural reference state
  logic [7:0] m_ctl0, m_ctl1;
  bit         m_done, m_ovf, m_armed;
  int         m_tmr, m_cap;
  bit         m_sync[$];
  bit         m_prev;

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_ctl0;
      3'd1: return {m_ctl1[7:4], 4'h0};
      3'd2: return {6'h00, m_ovf, m_done};
      3'd3: return m_tmr[7:0];
      3'd4: return m_tmr[15:8];
      3'd5: return m_cap[7:0];
      3'd6: return m_cap[15:8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] a);
    case (a)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R7";
      3'd3, 3'd4: return "R4";
      default: return "R5";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl0 = 8'h0F; m_ctl1 = 8'h00; m_done = 0; m_ovf = 0; m_armed = 1;
      m_tmr = 0; m_cap = 0; m_sync = '{0, 0}; m_prev = 0;
    end else begin
      bit hold, off, run, rise, trip, wrap, nd, no;
      hold = m_ctl0[3]; off = m_ctl0[2]; run = !hold && !off;
      rise = m_sync[1] && !m_prev;
      trip = clk_run && rise && m_armed && run;
      wrap = clk_run && run && m_armed && !trip && (m_tmr == 16'hFFFF);
      nd = m_done; no = m_ovf;
      if (wr_en && wr_addr == 3'd2) begin nd = m_done & wr_data[0]; no = m_ovf & wr_data[1]; end
      if (trip) nd = 1;
      if (wrap) no = 1;
      if (clk_run) begin
        if (trip) m_cap = m_tmr;
        if (hold) begin m_tmr = 0; m_armed = 1; end
        else begin
          if (!off) m_tmr = (m_tmr + 1) % 65536;
          if (trip) m_armed = 0;
        end
        m_prev = m_sync[1];
        m_sync.push_front(cmp_in);
        void'(m_sync.pop_back());
      end
      m_done = nd; m_ovf = no;
      if (wr_en && wr_addr == 3'd0) m_ctl0 = wr_data;
      if (wr_en && wr_addr == 3'd1) m_ctl1 = wr_data;
    end
  end

  task automatic chk(input string req, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("%s %s %s: actual %h expected %h", "FAIL", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R5", "done_irq", {15'd0, done_irq}, {15'd0, m_done});
      chk("R3", "isrc_en", {15'd0, isrc_en}, {15'd0, !m_ctl0[3] && !m_ctl0[2]});
      chk("R2", "chan_sel", {12'd0, chan_sel}, {12'd0, m_ctl0[7:4]});
      chk("R2", "ramp_iset", {12'd0, ramp_iset}, {12'd0, m_ctl1[7:4]});
      chk("R1", "off outputs", {13'd0, conv_off, ref_off, osc_off}, {13'd0, m_ctl0[2:0]});
      chk(req_of(rd_addr), "rd_data", {8'd0, rd_data}, {8'd0, m_read(rd_addr)});
    end
  end

  task automatic run_cycles(input int n);
    repeat (n) begin
      @(negedge clk); #1;
      rd_addr = (rd_addr >= 3'd6) ? 3'd0 : rd_addr + 3'd1;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic probe(input logic [2:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); #1;
    rd_addr = a; #1;
    chk(req, "probe", {8'd0, rd_data}, {8'd0, exp});
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    run_cycles(4);
    // R1: reset values
    probe(3'd0, 8'h0F, "R1");
    probe(3'd2, 8'h00, "R1");
    chk("R1", "isrc_en reset", {15'd0, isrc_en}, 16'd0);
    // R2: channel and current settings
    wr(3'd1, 8'hA5);
    wr(3'd0, 8'h38);
    probe(3'd1, 8'hA0, "R2");
    chk("R2", "chan_sel", {12'd0, chan_sel}, 16'd3);
    run_cycles(5);
    // R3 R4: release hold, count
    wr(3'd0, 8'h30);
    run_cycles(40);
    // R5: first trip
    cmp_in = 1'b1;
    run_cycles(10);
    probe(3'd2, 8'h01, "R5");
    // R6: later edges ignored
    cmp_in = 1'b0; run_cycles(8);
    cmp_in = 1'b1; run_cycles(8);
    probe(3'd2, 8'h01, "R6");
    run_cycles(7);
    // R7: write-one keeps, write-zero clears
    wr(3'd2, 8'h03);
    probe(3'd2, 8'h01, "R7");
    wr(3'd2, 8'h00);
    probe(3'd2, 8'h00, "R7");
    // R8: trip during a clock stop
    cmp_in = 1'b0;
    wr(3'd0, 8'h58);
    run_cycles(6);
    wr(3'd0, 8'h50);
    run_cycles(25);
    @(negedge clk); #1 clk_run = 1'b0;
    run_cycles(3);
    cmp_in = 1'b1;
    run_cycles(6);
    probe(3'd2, 8'h00, "R8");
    @(negedge clk); #1 clk_run = 1'b1;
    run_cycles(8);
    probe(3'd2, 8'h01, "R8");
    // R8: alternating clock stops while counting
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); #1 clk_run = i[0];
      rd_addr = 3'd3 + 3'(i % 4);
    end
    @(negedge clk); #1 clk_run = 1'b1;
    wr(3'd2, 8'h00);
    // R3: converter off freezes the count and drops the source
    cmp_in = 1'b0;
    wr(3'd0, 8'h34);
    run_cycles(12);
    chk("R3", "isrc_en off", {15'd0, isrc_en}, 16'd0);
    // R9: overflow without a trip
    wr(3'd0, 8'h38);
    run_cycles(4);
    wr(3'd0, 8'h30);
    run_cycles(65560);
    probe(3'd2, 8'h02, "R9");
    wr(3'd2, 8'h01);
    probe(3'd2, 8'h00, "R9");
    wr(3'd0, 8'h0F);
    run_cycles(6);
    probe(3'd0, 8'h0F, "R1");
    summary();
  end
endmodule